// File: doc/BRIEF.md
# Event State Buffer Page Handler

This block is a memory-mapped slave that gives every event-queue descriptor two adjacent pages of address space. One page of each pair works on the descriptor's notification P/Q bits. The other page works on its escalation P/Q bits. Software issues doubleword loads and stores. The address carries both the descriptor index and the operation, so each access needs no data payload.

For each accepted access, the block reads the descriptor's control word from an external table port. It then applies the P/Q operation that the offset selects and returns load data. It writes the control word back to the table only when the selected P/Q pair actually changed. A store that produces a notification raises a one-cycle `notify_o` pulse.

The page size is set by `PAGE_SHIFT`. Only 12 (4 KB pages) and 16 (64 KB pages) are accepted, and any other value stops elaboration with an error.

Top module: `esb_page_handler`

## Requirements
- R1: The descriptor index on `tbl_idx_o` is `addr_i >> (PAGE_SHIFT+1)`. Address bit `PAGE_SHIFT` = 0 selects the notification pair at control-word bits [NPQ_LSB+1:NPQ_LSB]. Bit `PAGE_SHIFT` = 1 selects the escalation pair at [EPQ_LSB+1:EPQ_LSB]. In each pair, P is the upper bit and Q the lower bit. The operation is decoded from `addr_i[11:8]`.
- R2: A load at offset 0x000–0x7FF performs an EOI, and returns the notification flag in data bit 0 with all other bits zero. The EOI moves 11 to 10 with the flag set, leaves 01 unchanged, and moves 00 or 10 to 00.
- R3: A load at offset 0x800–0xBFF returns the selected pair as {P,Q} in data bits [1:0] and leaves it unchanged.
- R4: A load at offset 0xC00–0xFFF sets the pair to offset bits [9:8] and returns the previous pair in data bits [1:0].
- R5: A store at offset 0x000–0x3FF performs a trigger. The trigger moves 00 to 10 and raises `notify_o`, moves 10 to 11, and leaves 11 and 01 unchanged. Only the move from 00 notifies.
- R6: A store at offset 0x400–0x7FF performs the EOI transition of R2, and raises `notify_o` when the flag is set.
- R7: A store at offset 0x800–0xBFF on a notification page raises `notify_o` and leaves P/Q unchanged. On an escalation page the same store is an error.
- R8: An access whose `size_i` is not 8, or a store at offset 0xC00–0xFFF, is an error. An error response sets `rsp_err_o`, performs no table write and no notify, and returns all-ones for a load.
- R9: When `tbl_hit_i` is low (the descriptor is missing or invalid), a load returns all-ones without error, and a store has no effect.
- R10: `tbl_wr_o` is raised only when the selected pair changes. `tbl_wdata_o` keeps every other bit of the control word that was read.
- R11: After reset, `ready_o` is high and all other outputs are low. An access accepted at clock edge k is answered with `rsp_valid_o` during the cycle after edge k+1. `ready_o` is low until that response ends. Store responses carry zero data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Access request, taken when `ready_o` is high |
| we_i | input | 1 | 1 = store, 0 = load |
| addr_i | input | ADDR_W | Byte address of the access |
| size_i | input | 4 | Access size in bytes; only 8 is valid |
| ready_o | output | 1 | Block is idle and accepts a request |
| tbl_rd_o | output | 1 | Control-word read strobe; data is returned one cycle later |
| tbl_idx_o | output | ADDR_W-PAGE_SHIFT-1 | Descriptor index for the read and the write |
| tbl_rdata_i | input | 32 | Control word read from the table |
| tbl_hit_i | input | 1 | Descriptor exists and is valid (same timing as `tbl_rdata_i`) |
| tbl_wr_o | output | 1 | Control-word write strobe |
| tbl_wdata_o | output | 32 | Updated control word |
| rsp_valid_o | output | 1 | Response cycle |
| rsp_data_o | output | 64 | Load data |
| rsp_err_o | output | 1 | Access was malformed or refused |
| notify_o | output | 1 | Store produced a notification |

## Verification
The bench builds the block with `PAGE_SHIFT` = 12 and `ADDR_W` = 24. With these values, a 4-bit table model covers several descriptor pairs using short addresses. It also keeps the index, the page-select bit and the offset in fixed fields that are easy to compose. The default field positions (notification pair at bit 0, escalation pair at bit 4) leave filler bits above both pairs, so a write-back that corrupts neighbouring bits is visible. The 64 KB variant is reached only through elaboration with the default parameters.

// File: rtl/esb_pkg.sv
package esb_pkg;
  localparam int OFF_W     = 12;
  localparam int SIZE_W    = 4;
  localparam int ACC_BYTES = 8;
  localparam int BUS_W     = 64;
  localparam int WORD_W    = 32;

  typedef logic [1:0] pq_t;

  typedef enum logic [2:0] {
    OP_LD_EOI,
    OP_LD_GET,
    OP_LD_SET,
    OP_ST_TRIG,
    OP_ST_EOI,
    OP_ST_INJ,
    OP_BAD
  } esb_op_e;
endpackage

// File: rtl/esb_op_decode.sv
module esb_op_decode
  import esb_pkg::*;
(
  input  logic              we_i,
  input  logic              esc_i,
  input  logic [3:0]        win_i,   // offset bits [11:8]
  input  logic [SIZE_W-1:0] size_i,
  output esb_op_e           op_o,
  output pq_t               set_pq_o
);
  assign set_pq_o = win_i[1:0];

  always_comb begin
    op_o = OP_BAD;
    if (size_i == SIZE_W'(ACC_BYTES)) begin
      if (!we_i) begin
        unique case (win_i[3:2])
          2'b00, 2'b01: op_o = OP_LD_EOI;
          2'b10:        op_o = OP_LD_GET;
          default:      op_o = OP_LD_SET;
        endcase
      end else begin
        unique case (win_i[3:2])
          2'b00:   op_o = OP_ST_TRIG;
          2'b01:   op_o = OP_ST_EOI;
          2'b10:   op_o = esc_i ? OP_BAD : OP_ST_INJ;
          default: op_o = OP_BAD;
        endcase
      end
    end
  end
endmodule

// File: rtl/esb_pq_step.sv
module esb_pq_step
  import esb_pkg::*;
(
  input  esb_op_e op_i,
  input  pq_t     pq_i,
  input  pq_t     set_pq_i,
  output pq_t     pq_o,
  output logic    ntf_o
);
  always_comb begin
    pq_o  = pq_i;
    ntf_o = 1'b0;
    unique case (op_i)
      OP_LD_EOI, OP_ST_EOI: begin
        if (pq_i == 2'b11) begin
          pq_o  = 2'b10;
          ntf_o = 1'b1;
        end else if (pq_i != 2'b01) begin
          pq_o = 2'b00;
        end
      end
      OP_LD_SET: pq_o = set_pq_i;
      OP_ST_TRIG: begin
        if (pq_i == 2'b00) begin
          pq_o  = 2'b10;
          ntf_o = 1'b1;
        end else if (pq_i == 2'b10) begin
          pq_o = 2'b11;
        end
      end
      OP_ST_INJ: ntf_o = 1'b1;
      default: ;
    endcase
  end

  // off state (01) is never left by EOI or trigger
  always_comb begin
    if ((op_i == OP_ST_TRIG || op_i == OP_LD_EOI || op_i == OP_ST_EOI) && pq_i == 2'b01)
      assert_off_sticky_R5: assert (pq_o == 2'b01 && !ntf_o);
  end
endmodule

// File: rtl/esb_page_handler.sv
module esb_page_handler
  import esb_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int PAGE_SHIFT = 16,
  parameter int NPQ_LSB    = 0,
  parameter int EPQ_LSB    = 4,
  localparam int IDX_W     = ADDR_W - PAGE_SHIFT - 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [SIZE_W-1:0] size_i,
  output logic              ready_o,
  output logic              tbl_rd_o,
  output logic [IDX_W-1:0]  tbl_idx_o,
  input  logic [WORD_W-1:0] tbl_rdata_i,
  input  logic              tbl_hit_i,
  output logic              tbl_wr_o,
  output logic [WORD_W-1:0] tbl_wdata_o,
  output logic              rsp_valid_o,
  output logic [BUS_W-1:0]  rsp_data_o,
  output logic              rsp_err_o,
  output logic              notify_o
);
  generate
    if (PAGE_SHIFT != 12 && PAGE_SHIFT != 16) begin : g_bad_shift
      $error("PAGE_SHIFT must be 12 or 16");
    end
    if (NPQ_LSB + 1 >= WORD_W || EPQ_LSB + 1 >= WORD_W ||
        (NPQ_LSB <= EPQ_LSB + 1 && EPQ_LSB <= NPQ_LSB + 1)) begin : g_bad_fields
      $error("P/Q field positions overlap or exceed the control word");
    end
  endgenerate

  typedef enum logic [1:0] {ST_IDLE, ST_LOOK, ST_EXEC} st_e;
  st_e st_q;

  logic              we_q;
  logic [ADDR_W-1:0] addr_q;
  logic [SIZE_W-1:0] size_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      we_q   <= 1'b0;
      addr_q <= '0;
      size_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (req_i) begin
          st_q   <= ST_LOOK;
          we_q   <= we_i;
          addr_q <= addr_i;
          size_q <= size_i;
        end
        ST_LOOK: st_q <= ST_EXEC;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  logic unused_low;
  assign unused_low = ^addr_q[7:0];
  generate
    if (PAGE_SHIFT > 12) begin : g_gap
      logic unused_gap;
      assign unused_gap = ^addr_q[PAGE_SHIFT-1:12];
    end
  endgenerate

  logic esc_sel;
  assign esc_sel = addr_q[PAGE_SHIFT];

  esb_op_e op;
  pq_t     set_pq, pq_old, pq_new;
  logic    ntf;

  esb_op_decode u_dec (
    .we_i     (we_q),
    .esc_i    (esc_sel),
    .win_i    (addr_q[11:8]),
    .size_i   (size_q),
    .op_o     (op),
    .set_pq_o (set_pq)
  );

  assign pq_old = esc_sel ? tbl_rdata_i[EPQ_LSB +: 2] : tbl_rdata_i[NPQ_LSB +: 2];

  esb_pq_step u_step (
    .op_i     (op),
    .pq_i     (pq_old),
    .set_pq_i (set_pq),
    .pq_o     (pq_new),
    .ntf_o    (ntf)
  );

  logic exec, bad, live;
  assign exec = (st_q == ST_EXEC);
  assign bad  = (op == OP_BAD);
  assign live = exec && tbl_hit_i && !bad;

  assign ready_o     = (st_q == ST_IDLE);
  assign tbl_rd_o    = (st_q == ST_LOOK);
  assign tbl_idx_o   = addr_q[ADDR_W-1:PAGE_SHIFT+1];
  assign tbl_wr_o    = live && (pq_new != pq_old);
  assign rsp_valid_o = exec;
  assign rsp_err_o   = exec && bad;
  assign notify_o    = live && we_q && ntf;

  always_comb begin
    tbl_wdata_o = tbl_rdata_i;
    if (esc_sel) tbl_wdata_o[EPQ_LSB +: 2] = pq_new;
    else         tbl_wdata_o[NPQ_LSB +: 2] = pq_new;
  end

  always_comb begin
    rsp_data_o = '0;
    if (exec && !we_q) begin
      if (bad || !tbl_hit_i)        rsp_data_o = '1;
      else if (op == OP_LD_EOI)     rsp_data_o[0]   = ntf;
      else                          rsp_data_o[1:0] = pq_old;
    end
  end

  assert_wb_only_live_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tbl_wr_o |-> rsp_valid_o && !rsp_err_o && tbl_hit_i);
  assert_err_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_err_o |-> !tbl_wr_o && !notify_o);
  assert_miss_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !tbl_hit_i) |-> !tbl_wr_o && !notify_o);
  assert_lookup_first_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> $past(tbl_rd_o) && !ready_o);
  assert_idx_held_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> $stable(tbl_idx_o));
  assert_notify_ok_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    notify_o |-> rsp_valid_o && !rsp_err_o);
endmodule

// File: tb/esb_page_handler_test.sv
module esb_page_handler_test;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 24;
  localparam int PAGE_SHIFT = 12;
  localparam int IDX_W      = ADDR_W - PAGE_SHIFT - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic              req = 1'b0, we = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [3:0]        size = 4'd8;
  logic              ready, tbl_rd, tbl_hit, tbl_wr, rsp_valid, rsp_err, notify;
  logic [IDX_W-1:0]  tbl_idx;
  logic [31:0]       tbl_rdata, tbl_wdata;
  logic [63:0]       rsp_data;

  esb_page_handler #(.ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT)) uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr), .size_i(size),
    .ready_o(ready), .tbl_rd_o(tbl_rd), .tbl_idx_o(tbl_idx), .tbl_rdata_i(tbl_rdata),
    .tbl_hit_i(tbl_hit), .tbl_wr_o(tbl_wr), .tbl_wdata_o(tbl_wdata),
    .rsp_valid_o(rsp_valid), .rsp_data_o(rsp_data), .rsp_err_o(rsp_err), .notify_o(notify)
  );

  // table model
  logic [31:0] mem [16];
  logic        hitmap [16];
  always @(posedge clk) begin
    if (tbl_rd) begin
      tbl_rdata <= mem[tbl_idx[3:0]];
      tbl_hit   <= hitmap[tbl_idx[3:0]];
    end
    if (tbl_wr) mem[tbl_idx[3:0]] <= tbl_wdata;
  end

  int cyc = 0;
  int checks = 0;
  int fails = 0;

  typedef struct {
    string       tag;
    logic [63:0] data;
    logic        err;
    logic        ntf;
    logic        wr;
    logic [31:0] wdata;
    logic [3:0]  idx;
    int          cyc;
  } exp_t;
  exp_t sb[$];

  logic [31:0] ref_w [16];
  logic        ref_hit [16];

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      fails++;
      $display("FAIL watchdog: actual running expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  // monitor
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (sb.size() == 0) begin
        chk("R11", "unexpected response", 64'd1, 64'd0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk(e.tag, "timing", 64'(cyc), 64'(e.cyc));
        chk(e.tag, "R1 idx", 64'(tbl_idx), 64'(e.idx));
        chk(e.tag, "data", rsp_data, e.data);
        chk(e.tag, "err", 64'(rsp_err), 64'(e.err));
        chk(e.tag, "notify", 64'(notify), 64'(e.ntf));
        chk(e.tag, "R10 wr", 64'(tbl_wr), 64'(e.wr));
        if (e.wr) chk(e.tag, "R10 wdata", 64'(tbl_wdata), 64'(e.wdata));
      end
    end
  end

  // driver: computes expectations from the requirements, then issues the access
  task automatic access(string tag, logic w, logic [3:0] idx, logic esc,
                        logic [11:0] off, logic [3:0] sz = 4'd8);
    exp_t e;
    logic [1:0] old_pq, new_pq;
    logic       bad, n;
    int         lsb;
    lsb    = esc ? 4 : 0;
    old_pq = ref_w[idx][lsb +: 2];
    new_pq = old_pq;
    n      = 1'b0;
    bad    = (sz != 4'd8) || (w && off >= 12'hC00) || (w && esc && off >= 12'h800);
    e.tag = tag; e.idx = idx; e.err = bad; e.data = '0; e.ntf = 1'b0;
    e.wr = 1'b0; e.wdata = ref_w[idx];
    if (bad) begin
      if (!w) e.data = '1;
    end else if (!ref_hit[idx]) begin
      if (!w) e.data = '1;
    end else begin
      if ((!w && off < 12'h800) || (w && off >= 12'h400 && off < 12'h800)) begin
        if (old_pq == 2'b11) begin new_pq = 2'b10; n = 1'b1; end
        else if (old_pq != 2'b01) new_pq = 2'b00;
        if (!w) e.data = {63'd0, n};
      end else if (!w && off < 12'hC00) begin
        e.data = {62'd0, old_pq};
      end else if (!w) begin
        new_pq = off[9:8];
        e.data = {62'd0, old_pq};
      end else if (off < 12'h400) begin
        if (old_pq == 2'b00) begin new_pq = 2'b10; n = 1'b1; end
        else if (old_pq == 2'b10) new_pq = 2'b11;
      end else begin
        n = 1'b1;
      end
      e.ntf = w && n;
      e.wr  = (new_pq != old_pq);
      e.wdata[lsb +: 2] = new_pq;
      ref_w[idx] = e.wdata;
    end
    @(negedge clk);
    while (!ready) @(negedge clk);
    req = 1'b1; we = w; size = sz;
    addr = {7'd0, idx, esc, off};
    @(posedge clk);
    @(negedge clk);
    e.cyc = cyc + 1;
    sb.push_back(e);
    req = 1'b0;
    while (!ready) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) begin
      mem[i] = 32'h0; hitmap[i] = 1'b0;
    end
    mem[1] = 32'hA5A5_0000; hitmap[1] = 1'b1;
    mem[3] = 32'h1234_5600; hitmap[3] = 1'b1;
    for (int i = 0; i < 16; i++) begin
      ref_w[i] = mem[i]; ref_hit[i] = hitmap[i];
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11", "reset ready", 64'(ready), 64'd1);
    chk("R11", "reset rsp_valid", 64'(rsp_valid), 64'd0);
    chk("R11", "reset tbl_wr", 64'(tbl_wr), 64'd0);
    chk("R11", "reset notify", 64'(notify), 64'd0);

    access("R3 get", 0, 1, 0, 12'h800);
    access("R5 trig 00", 1, 1, 0, 12'h000);
    access("R5 trig 10", 1, 1, 0, 12'h3F8);
    access("R5 trig 11", 1, 1, 0, 12'h100);
    access("R2 eoi 11", 0, 1, 0, 12'h000);
    access("R2 eoi 10", 0, 1, 0, 12'h7F8);
    access("R4 set 01", 0, 1, 0, 12'hD00);
    access("R5 trig off", 1, 1, 0, 12'h000);
    access("R2 eoi off", 0, 1, 0, 12'h400);
    access("R4 set 11", 0, 1, 0, 12'hF00);
    access("R6 seoi 11", 1, 1, 0, 12'h400);
    access("R6 seoi 10", 1, 1, 0, 12'h7F8);
    access("R1 esc trig", 1, 1, 1, 12'h000);
    access("R1 R3 esc get", 0, 1, 1, 12'hBF8);
    access("R3 notif get", 0, 1, 0, 12'h900);
    access("R7 inject", 1, 1, 0, 12'h800);
    access("R7 inject esc", 1, 1, 1, 12'h800);
    access("R8 store undef", 1, 1, 0, 12'hC00);
    access("R8 bad size ld", 0, 1, 0, 12'h800, 4'd4);
    access("R8 bad size st", 1, 1, 0, 12'h000, 4'd2);
    access("R9 miss load", 0, 2, 0, 12'h800);
    access("R9 miss store", 1, 2, 0, 12'h000);
    access("R9 miss after", 0, 2, 0, 12'hC00);
    access("R10 set idx3", 0, 3, 0, 12'hE00);
    access("R10 esc set idx3", 0, 3, 1, 12'hF00);
    access("R10 get idx3", 0, 3, 1, 12'hA00);

    repeat (4) @(negedge clk);
    chk("R11", "pending responses", 64'(sb.size()), 64'd0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule